// File: doc/BRIEF.md
# Flow-Through Burst SRAM Cycle Controller

This block models a synchronous burst SRAM with flow-through reads. The array is small and parameterised, with 36-bit words. On every rising clock edge the block decodes three chip selects, a load/advance strobe, a write strobe and four byte-lane write strobes. From these it starts, steps, aborts or ends read and write bursts. A clock-enable input can freeze an edge. A snooze input overrides everything else.

Read data comes straight from the array for the address registered on the last accepted edge. There is no output register. Write data is taken on the same edge as the address it goes to. The bidirectional data pin is split into three ports: a data-out port, a data-in port and a drive-enable flag. The output-enable input and the snooze input gate the drive-enable flag without waiting for a clock edge.

A burst covers four words. The words share the upper address bits and differ in the two low bits. A static order input picks how those two low bits step: an XOR (interleaved) order or a modulo-4 increment (linear) order.

Top module: `fts_sram_ctrl`

## Requirements
- R1: On an accepted edge with `adv_ld` low, any of `sel1_n` high, `sel2` low or `sel3_n` high deselects the block. `rdata_drv` is 0 after that edge, no word of the array changes, and any burst in progress ends.
- R2: On an accepted edge with `adv_ld` high and no burst in progress, nothing is written and `rdata_drv` stays 0.
- R3: A selected, accepted edge with `adv_ld` low and `wr_n` high starts a read burst at `addr`. While `out_en_n` is low, `rdata_drv` is 1 after that edge and `rdata` equals the stored word at `addr`.
- R4: While `out_en_n` is high, `rdata_drv` is 0 at once, with no clock edge needed. A read beat taken in that state is a dummy read and still steps the burst.
- R5: A selected, accepted edge with `adv_ld` low and `wr_n` low starts a write burst at `addr`. On that edge and on each continued beat, `wdata` is written only into the lanes whose strobe is low. The lanes are: `lane_wr_n[0]` for bits 8:0, `lane_wr_n[1]` for bits 17:9, `lane_wr_n[2]` for bits 26:18 and `lane_wr_n[3]` for bits 35:27. `rdata_drv` is 0 on write beats.
- R6: A write beat with `lane_wr_n` = 4'b1111 is an abort. The word is left unchanged and the bus is not driven.
- R7: With `lin_order` = 0, each accepted `adv_ld`-high edge during a burst moves on to the next beat of the same kind. Beat k of a burst that started at address A goes to {A[high bits], A[1:0] XOR k}, with k counted modulo 4.
- R8: With `lin_order` = 1, beat k goes to {A[high bits], (A[1:0] + k) mod 4}. In both orders the fifth beat wraps back to A.
- R9: An edge with `clk_en_n` high is ignored. No write happens, and the burst state, `rdata` and the registered read-valid state stay as they were.
- R10: While `snooze` is high, `rdata_drv` is 0 at once. An edge taken during snooze does nothing and ends any burst.
- R11: After reset, `rdata_drv` is 0 and no burst is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel1_n | input | 1 | Chip select 1, active low |
| sel2 | input | 1 | Chip select 2, active high |
| sel3_n | input | 1 | Chip select 3, active low |
| adv_ld | input | 1 | 0 = load a new address, 1 = advance the current burst |
| wr_n | input | 1 | Write strobe, active low, sampled on load |
| lane_wr_n | input | 4 | Per-lane write strobes, active low |
| out_en_n | input | 1 | Output enable, active low, acts without a clock edge |
| clk_en_n | input | 1 | Clock enable, active low |
| snooze | input | 1 | Sleep override, active high |
| lin_order | input | 1 | Burst order: 1 = linear, 0 = interleaved |
| addr | input | ADDR_W | Word address |
| wdata | input | 36 | Write data |
| rdata | output | 36 | Read data, flow-through |
| rdata_drv | output | 1 | Drive enable for `rdata` |

## Verification
Directed cases come first. They cover:
- a deselected write followed by a read of the same address, which separates a deselect from a real write;
- `out_en_n` toggled between two edges, which shows that output gating does not wait for the clock;
- an all-lanes-high write, which separates an abort from a write;
- a read burst run past its fourth beat in each order, which separates XOR stepping from modulo-4 stepping and confirms the wrap.

Constrained random phases follow, one per burst order. They mix loads, advances, deselects, stalls, snooze and partial lane masks. Each read beat is compared with a reference array in the bench, so a wrong lane mask or a wrong beat address shows up on a later read.

// File: rtl/fts_pkg.sv
package fts_pkg;
  localparam int WORD_W = 36;
  localparam int LANES  = 4;
  localparam int LANE_W = WORD_W / LANES;

  // Per-edge action chosen by the cycle decoder
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,  // clock edge ignored
    OP_STOP = 2'd1,  // deselect, snooze, or advance with no burst
    OP_LOAD = 2'd2,  // begin burst at external address
    OP_STEP = 2'd3   // next beat of running burst
  } op_e;
endpackage

// File: rtl/fts_cycle_dec.sv
module fts_cycle_dec
  import fts_pkg::*;
(
  input  logic sel1_n,
  input  logic sel2,
  input  logic sel3_n,
  input  logic adv_ld,
  input  logic clk_en_n,
  input  logic snooze,
  input  logic burst_act,
  output op_e  op
);
  logic chip_sel;

  assign chip_sel = !sel1_n && sel2 && !sel3_n;

  // Priority: snooze, then stall, then load/advance
  always_comb begin
    if (snooze)          op = OP_STOP;
    else if (clk_en_n)   op = OP_HOLD;
    else if (!adv_ld)    op = chip_sel ? OP_LOAD : OP_STOP;
    else if (burst_act)  op = OP_STEP;
    else                 op = OP_STOP;
  end
endmodule

// File: rtl/fts_burst_seq.sv
module fts_burst_seq (
  input  logic       lin_order,
  input  logic [1:0] start_lo,
  input  logic [1:0] beat,
  output logic [1:0] addr_lo
);
  // Interleaved order flips bits, linear order adds modulo four
  always_comb begin
    if (lin_order) addr_lo = start_lo + beat;
    else           addr_lo = start_lo ^ beat;
  end
endmodule

// File: rtl/fts_array.sv
module fts_array
  import fts_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [LANES-1:0]  lane_n,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  // One storage bank per byte lane so each lane has a single writer
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] bank [DEPTH];

    always_ff @(posedge clk) begin
      if (we && !lane_n[g]) bank[waddr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = bank[raddr];
  end
endmodule

// File: rtl/fts_sram_ctrl.sv
module fts_sram_ctrl
  import fts_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel1_n,
  input  logic              sel2,
  input  logic              sel3_n,
  input  logic              adv_ld,
  input  logic              wr_n,
  input  logic [3:0]        lane_wr_n,
  input  logic              out_en_n,
  input  logic              clk_en_n,
  input  logic              snooze,
  input  logic              lin_order,
  input  logic [ADDR_W-1:0] addr,
  input  logic [35:0]       wdata,
  output logic [35:0]       rdata,
  output logic              rdata_drv
);
  localparam int HI_W = ADDR_W - 2;

  op_e               op;
  logic              act_q, act_d;
  logic              wrb_q, wrb_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [1:0]        beat_q, beat_d;
  logic [ADDR_W-1:0] cur_q, cur_d;
  logic              rdv_q, rdv_d;
  logic              mem_we;
  logic [1:0]        step_beat;
  logic [1:0]        step_lo;

  fts_cycle_dec u_dec (
    .sel1_n   (sel1_n),
    .sel2     (sel2),
    .sel3_n   (sel3_n),
    .adv_ld   (adv_ld),
    .clk_en_n (clk_en_n),
    .snooze   (snooze),
    .burst_act(act_q),
    .op       (op)
  );

  assign step_beat = beat_q + 2'd1;

  fts_burst_seq u_seq (
    .lin_order(lin_order),
    .start_lo (base_q[1:0]),
    .beat     (step_beat),
    .addr_lo  (step_lo)
  );

  // Next-state logic
  always_comb begin
    act_d  = act_q;
    wrb_d  = wrb_q;
    base_d = base_q;
    beat_d = beat_q;
    cur_d  = cur_q;
    rdv_d  = rdv_q;
    mem_we = 1'b0;
    unique case (op)
      OP_HOLD: ;
      OP_STOP: begin
        act_d = 1'b0;
        rdv_d = 1'b0;
      end
      OP_LOAD: begin
        act_d  = 1'b1;
        wrb_d  = !wr_n;
        base_d = addr;
        beat_d = 2'd0;
        cur_d  = addr;
        rdv_d  = wr_n;
        mem_we = !wr_n;
      end
      OP_STEP: begin
        beat_d = step_beat;
        cur_d  = {base_q[ADDR_W-1 -: HI_W], step_lo};
        rdv_d  = !wrb_q;
        mem_we = wrb_q;
      end
      default: ;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      wrb_q  <= 1'b0;
      base_q <= '0;
      beat_q <= 2'd0;
      cur_q  <= '0;
      rdv_q  <= 1'b0;
    end else begin
      act_q  <= act_d;
      wrb_q  <= wrb_d;
      base_q <= base_d;
      beat_q <= beat_d;
      cur_q  <= cur_d;
      rdv_q  <= rdv_d;
    end
  end

  fts_array #(.ADDR_W(ADDR_W)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .lane_n(lane_wr_n),
    .waddr (cur_d),
    .wdata (wdata),
    .raddr (cur_q),
    .rdata (rdata)
  );

  // Output gating is asynchronous on output enable and snooze
  assign rdata_drv = rdv_q && !out_en_n && !snooze;
endmodule

// File: rtl/fts_sram_chk.sv
module fts_sram_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel1_n,
  input logic              sel2,
  input logic              sel3_n,
  input logic              adv_ld,
  input logic              wr_n,
  input logic              out_en_n,
  input logic              clk_en_n,
  input logic              snooze,
  input logic [ADDR_W-1:0] addr,
  input logic              rdata_drv,
  input logic              act_q,
  input logic              rdv_q,
  input logic [ADDR_W-1:0] cur_q
);
  logic live, desel;

  assign live  = !snooze && !clk_en_n;
  assign desel = sel1_n || !sel2 || sel3_n;

  assert_desel_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !adv_ld && desel) |=> (!rdv_q && !act_q));

  assert_read_begin_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !adv_ld && !desel && wr_n) |=> (rdv_q && cur_q == $past(addr)));

  assert_oe_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> !rdata_drv);

  assert_step_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (live && adv_ld && act_q) |=> (cur_q[ADDR_W-1:2] == $past(cur_q[ADDR_W-1:2])));

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en_n && !snooze) |=> ($stable(cur_q) && $stable(rdv_q) && $stable(act_q)));

  assert_snooze_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    snooze |=> (!act_q && !rdv_q));
endmodule

bind fts_sram_ctrl fts_sram_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .sel1_n   (sel1_n),
  .sel2     (sel2),
  .sel3_n   (sel3_n),
  .adv_ld   (adv_ld),
  .wr_n     (wr_n),
  .out_en_n (out_en_n),
  .clk_en_n (clk_en_n),
  .snooze   (snooze),
  .addr     (addr),
  .rdata_drv(rdata_drv),
  .act_q    (act_q),
  .rdv_q    (rdv_q),
  .cur_q    (cur_q)
);

// File: tb/fts_sram_ctrl_tb.sv
`timescale 1ns/100ps
module fts_sram_ctrl_tb_top;
  localparam int AW    = 8;
  localparam int DEPTH = 1 << AW;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sel1_n, sel2, sel3_n, adv_ld, wr_n, out_en_n, clk_en_n, snooze, lin_order;
  logic [3:0]  lane_wr_n;
  logic [AW-1:0] addr;
  logic [35:0] wdata, rdata;
  logic        rdata_drv;

  int checks = 0;
  int errors = 0;

  // Reference state built from the requirements
  logic [35:0]   ref_mem [DEPTH];
  logic          m_act, m_wr, m_rd;
  logic [AW-1:0] m_base, m_cur;
  logic [1:0]    m_beat;
  string         m_tag;

  always #2.5 clk = ~clk;

  fts_sram_ctrl #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
    .adv_ld(adv_ld), .wr_n(wr_n), .lane_wr_n(lane_wr_n), .out_en_n(out_en_n),
    .clk_en_n(clk_en_n), .snooze(snooze), .lin_order(lin_order), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rdata_drv(rdata_drv)
  );

  function automatic logic [35:0] merge(input logic [35:0] old, input logic [35:0] nw,
                                        input logic [3:0] ln);
    logic [35:0] r = old;
    for (int i = 0; i < 4; i++) if (!ln[i]) r[i*9 +: 9] = nw[i*9 +: 9];
    return r;
  endfunction

  function automatic logic [1:0] seq_lo(input logic lin, input logic [1:0] s, input logic [1:0] k);
    return lin ? 2'(s + k) : (s ^ k);
  endfunction

  task automatic model_edge();
    if (snooze) begin
      m_act = 0; m_rd = 0; m_tag = "R10";
    end else if (clk_en_n) begin
      m_tag = "R9";
    end else if (!adv_ld) begin
      if (sel1_n || !sel2 || sel3_n) begin
        m_act = 0; m_rd = 0; m_tag = "R1";
      end else begin
        m_act = 1; m_wr = !wr_n; m_base = addr; m_beat = 0; m_cur = addr; m_rd = wr_n;
        if (!wr_n) begin
          ref_mem[addr] = merge(ref_mem[addr], wdata, lane_wr_n);
          m_tag = (lane_wr_n == 4'hF) ? "R6" : "R5";
        end else m_tag = out_en_n ? "R4" : "R3";
      end
    end else if (m_act) begin
      m_beat = m_beat + 2'd1;
      m_cur  = {m_base[AW-1:2], seq_lo(lin_order, m_base[1:0], m_beat)};
      m_rd   = !m_wr;
      if (m_wr) ref_mem[m_cur] = merge(ref_mem[m_cur], wdata, lane_wr_n);
      m_tag  = m_wr ? "R5" : (lin_order ? "R8" : "R7");
    end else begin
      m_rd = 0; m_tag = "R2";
    end
  endtask

  task automatic check_bus(input string tag);
    logic exp_en = m_rd && !out_en_n && !snooze;
    checks++;
    if (rdata_drv !== exp_en) begin
      errors++;
      $display("FAIL %s: rdata_drv=%0b expected %0b", tag, rdata_drv, exp_en);
    end else if (exp_en && rdata !== ref_mem[m_cur]) begin
      errors++;
      $display("FAIL %s: rdata=%h expected %h", tag, rdata, ref_mem[m_cur]);
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    #1;
    check_bus(m_tag);
  endtask

  task automatic idle_in();
    sel1_n = 0; sel2 = 1; sel3_n = 0; adv_ld = 1; wr_n = 1; lane_wr_n = 4'hF;
    out_en_n = 0; clk_en_n = 0; snooze = 0;
  endtask

  task automatic load(input logic [AW-1:0] a, input logic w, input logic [3:0] ln,
                      input logic [35:0] d);
    idle_in(); adv_ld = 0; addr = a; wr_n = w; lane_wr_n = ln; wdata = d;
    step();
  endtask

  task automatic adv(input logic [3:0] ln, input logic [35:0] d);
    idle_in(); lane_wr_n = ln; wdata = d;
    step();
  endtask

  task automatic rand_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      sel1_n    = ($urandom_range(0, 11) == 0);
      sel2      = ($urandom_range(0, 11) != 0);
      sel3_n    = ($urandom_range(0, 11) == 0);
      adv_ld    = ($urandom_range(0, 2) != 0);
      wr_n      = $urandom_range(0, 1);
      lane_wr_n = 4'($urandom);
      out_en_n  = ($urandom_range(0, 3) == 0);
      clk_en_n  = ($urandom_range(0, 7) == 0);
      snooze    = ($urandom_range(0, 19) == 0);
      addr      = AW'($urandom);
      wdata     = {4'($urandom), 32'($urandom)};
      step();
    end
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    idle_in(); lin_order = 0; addr = '0; wdata = '0;
    m_act = 0; m_wr = 0; m_rd = 0; m_base = '0; m_cur = '0; m_beat = 0; m_tag = "R11";
    rst_n = 0;
    #12;
    checks++;  // R11 reset state
    if (rdata_drv !== 1'b0) begin
      errors++; $display("FAIL R11: rdata_drv=%0b expected 0", rdata_drv);
    end
    @(negedge clk); rst_n = 1;
    step();  // advance with nothing active: R2

    // Preload every word with interleaved write bursts (R5, R7)
    for (int k = 0; k < DEPTH / 4; k++) begin
      load(AW'(k * 4), 1'b0, 4'h0, {4'($urandom), 32'($urandom)});
      for (int b = 0; b < 3; b++) adv(4'h0, {4'($urandom), 32'($urandom)});
    end

    // R1: deselected write must not land, read it back
    load(8'd5, 1'b0, 4'h0, 36'h0);
    idle_in(); adv_ld = 0; sel2 = 0; wr_n = 0; lane_wr_n = 4'h0; addr = 8'd5;
    wdata = 36'hABCDE1234; step();
    adv(4'h0, 36'h5);           // R2: continue deselect, nothing written
    load(8'd5, 1'b1, 4'hF, 36'h0);

    // R5: partial lane write (lanes b and d) then read
    load(8'd20, 1'b0, 4'b0101, 36'hFFFFFFFFF);
    load(8'd20, 1'b1, 4'hF, 36'h0);

    // R4: asynchronous output enable between edges
    load(8'd9, 1'b1, 4'hF, 36'h0);
    out_en_n = 1; #0.5; check_bus("R4");
    out_en_n = 0; #0.5; check_bus("R4");
    // R10: snooze gates immediately
    snooze = 1; #0.3; check_bus("R10");
    snooze = 0; #0.3; check_bus("R10");

    // R6: all-lanes-high write is an abort
    load(8'd12, 1'b0, 4'hF, 36'h123456789);
    load(8'd12, 1'b1, 4'hF, 36'h0);

    // R9: stall holds read beat
    load(8'd33, 1'b1, 4'hF, 36'h0);
    idle_in(); clk_en_n = 1; adv_ld = 0; addr = 8'd40; step();

    // R7: interleaved read burst from 6 with wrap; R8: linear from 6
    load(8'd6, 1'b1, 4'hF, 36'h0);
    for (int b = 0; b < 4; b++) adv(4'hF, 36'h0);
    lin_order = 1;
    load(8'd6, 1'b1, 4'hF, 36'h0);
    for (int b = 0; b < 4; b++) adv(4'hF, 36'h0);
    // R8: linear write burst starting at 3
    load(8'd3, 1'b0, 4'h0, 36'h111111111);
    for (int b = 0; b < 3; b++) adv(4'h0, 36'(b + 2));
    load(8'd3, 1'b1, 4'hF, 36'h0);
    for (int b = 0; b < 3; b++) adv(4'hF, 36'h0);

    // Random phases in each order
    lin_order = 0; rand_cycles(1500);
    lin_order = 1; rand_cycles(1500);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule